// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit single-cycle instruction into the control bits that steer the datapath. It decodes in two stages. A main stage reads only the 6-bit opcode. It sets the multiplexer selects, the write and read enables, the branch and jump flags, and a 2-bit ALU class code. A second stage combines that class code with the 6-bit function field. It produces a B-input negate bit and a 2-bit result select for an ALU built from an AND/OR unit, an adder and a less-than unit.

The decode logic is combinational. The outputs are registered, so every control bit appears one clock after its opcode and function field are presented. When the opcode or the function field is not in the supported subset, the block drops every write enable and both control-flow flags, so a stray encoding cannot change architectural state.

Top module: `ctrl_decoder`

## Requirements
- R1: A synchronous active-high reset clears every output to 0 at the clock edge, whatever the opcode and function inputs are.
- R2: Opcode 0 (register type) with a supported function code gives reg_dst=1, reg_write=1, alu_op=2'b10, and alu_src, mem_to_reg, mem_read, mem_write, branch and jump all 0.
- R3: Opcode 35 (load word) gives alu_src=1, mem_to_reg=1, reg_write=1, mem_read=1, alu_op=2'b00, and reg_dst, mem_write, branch and jump all 0.
- R4: Opcode 43 (store word) gives alu_src=1, mem_write=1, alu_op=2'b00, and every other main control 0 (the don't-care selects are driven to 0).
- R5: Opcode 4 (branch if equal) gives branch=1, alu_op=2'b01, and every other main control 0.
- R6: Opcode 2 (jump) gives jump=1, alu_op=2'b00, and every other main control 0.
- R7: Any other opcode drives all main controls and alu_op to 0, and drives b_neg=0 and alu_sel=2'b10.
- R8: When alu_op is 2'b00 the ALU stage gives b_neg=0 and alu_sel=2'b10 (add). When alu_op is 2'b01 it gives b_neg=1 and alu_sel=2'b10 (subtract). In both cases the function field is ignored.
- R9: When alu_op is 2'b10 the function field selects the ALU command. alu_sel encodes 00=AND, 01=OR, 10=adder, 11=less-than. The codes are 0x24 → (b_neg 0, sel 00), 0x25 → (0, 01), 0x20 → (0, 10), 0x22 → (1, 10) and 0x2A → (1, 11).
- R10: Opcode 0 with any other function code gives reg_write=0, b_neg=0 and alu_sel=2'b00. The remaining register-type controls stay as in R2.
- R11: Every output is registered. It reflects the opcode and function field that were sampled at the previous rising edge, and it holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| reg_dst | output | 1 | Destination register select: 1 selects the rd field, 0 selects the rt field |
| alu_src | output | 1 | ALU B operand: 1 selects the sign-extended immediate |
| mem_to_reg | output | 1 | Write-back source: 1 selects the load data |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |
| branch | output | 1 | Conditional branch flag |
| jump | output | 1 | Unconditional jump flag |
| alu_op | output | 2 | ALU class code passed between the two stages |
| b_neg | output | 1 | Invert B and carry in 1 |
| alu_sel | output | 2 | ALU result select |

## Verification
The hardest case to reach is a register-type opcode that carries a function code outside the supported five. Here the write enable has to fall while the other register-type selects stay as they are. A test that only replays real instruction streams would never produce this case. The stimulus therefore sweeps the full product of all 64 opcodes and all 64 function codes. Each sweep entry is scored against an independent model. This covers every reserved combination, including the ones where the function field must be ignored. A second hard case is a reset that arrives while a load is being presented. It is checked separately to confirm that the reset clears the outputs even with a live opcode on the inputs.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  typedef enum logic [1:0] {
    AOP_ADD = 2'b00,
    AOP_SUB = 2'b01,
    AOP_FN  = 2'b10,
    AOP_RSV = 2'b11
  } aop_e;

  typedef enum logic [1:0] {
    SEL_AND = 2'b00,
    SEL_OR  = 2'b01,
    SEL_SUM = 2'b10,
    SEL_LT  = 2'b11
  } sel_e;

  typedef struct packed {
    logic reg_dst;
    logic alu_src;
    logic mem_to_reg;
    logic reg_write;
    logic mem_read;
    logic mem_write;
    logic branch;
    logic jump;
    aop_e aop;
  } main_ctrl_t;

  localparam logic [OPC_W-1:0] OP_RT  = OPC_W'(0);
  localparam logic [OPC_W-1:0] OP_LW  = OPC_W'(35);
  localparam logic [OPC_W-1:0] OP_SW  = OPC_W'(43);
  localparam logic [OPC_W-1:0] OP_BEQ = OPC_W'(4);
  localparam logic [OPC_W-1:0] OP_J   = OPC_W'(2);

  localparam logic [FN_W-1:0] FN_ADD = FN_W'(6'h20);
  localparam logic [FN_W-1:0] FN_SUB = FN_W'(6'h22);
  localparam logic [FN_W-1:0] FN_AND = FN_W'(6'h24);
  localparam logic [FN_W-1:0] FN_OR  = FN_W'(6'h25);
  localparam logic [FN_W-1:0] FN_SLT = FN_W'(6'h2A);
endpackage

// File: rtl/main_dec.sv
module main_dec
  import ctrl_dec_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic [OW-1:0] opcode,
  output main_ctrl_t    ctrl
);
  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_RT: begin
        ctrl.reg_dst   = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.aop       = AOP_FN;
      end
      OP_LW: begin
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_write  = 1'b1;
        ctrl.mem_read   = 1'b1;
        ctrl.aop        = AOP_ADD;
      end
      OP_SW: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
        ctrl.aop       = AOP_ADD;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aop    = AOP_SUB;
      end
      OP_J: begin
        ctrl.jump = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/alu_ctl.sv
module alu_ctl
  import ctrl_dec_pkg::*;
#(
  parameter int FW = FN_W
) (
  input  aop_e          aop,
  input  logic [FW-1:0] funct,
  output logic          b_neg,
  output sel_e          sel,
  output logic          fn_ok
);
  always_comb begin
    b_neg = 1'b0;
    sel   = SEL_SUM;
    fn_ok = 1'b1;
    case (aop)
      AOP_ADD: begin
        b_neg = 1'b0;
        sel   = SEL_SUM;
      end
      AOP_SUB: begin
        b_neg = 1'b1;
        sel   = SEL_SUM;
      end
      AOP_FN: begin
        case (funct)
          FN_ADD: begin b_neg = 1'b0; sel = SEL_SUM; end
          FN_SUB: begin b_neg = 1'b1; sel = SEL_SUM; end
          FN_AND: begin b_neg = 1'b0; sel = SEL_AND; end
          FN_OR:  begin b_neg = 1'b0; sel = SEL_OR;  end
          FN_SLT: begin b_neg = 1'b1; sel = SEL_LT;  end
          default: begin
            b_neg = 1'b0;
            sel   = SEL_AND;
            fn_ok = 1'b0;
          end
        endcase
      end
      default: begin
        b_neg = 1'b0;
        sel   = SEL_AND;
        fn_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_dec_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int FW = FN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode,
  input  logic [FW-1:0] funct,
  output logic          reg_dst,
  output logic          alu_src,
  output logic          mem_to_reg,
  output logic          reg_write,
  output logic          mem_read,
  output logic          mem_write,
  output logic          branch,
  output logic          jump,
  output logic [1:0]    alu_op,
  output logic          b_neg,
  output logic [1:0]    alu_sel
);
  main_ctrl_t mc;
  logic       bn_c;
  sel_e       sel_c;
  logic       fn_ok_c;

  main_dec #(.OW(OW)) u_main (
    .opcode (opcode),
    .ctrl   (mc)
  );

  alu_ctl #(.FW(FW)) u_alu (
    .aop   (mc.aop),
    .funct (funct),
    .b_neg (bn_c),
    .sel   (sel_c),
    .fn_ok (fn_ok_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_dst    <= 1'b0;
      alu_src    <= 1'b0;
      mem_to_reg <= 1'b0;
      reg_write  <= 1'b0;
      mem_read   <= 1'b0;
      mem_write  <= 1'b0;
      branch     <= 1'b0;
      jump       <= 1'b0;
      alu_op     <= 2'b00;
      b_neg      <= 1'b0;
      alu_sel    <= 2'b00;
    end else begin
      reg_dst    <= mc.reg_dst;
      alu_src    <= mc.alu_src;
      mem_to_reg <= mc.mem_to_reg;
      reg_write  <= mc.reg_write & fn_ok_c;
      mem_read   <= mc.mem_read;
      mem_write  <= mc.mem_write;
      branch     <= mc.branch;
      jump       <= mc.jump;
      alu_op     <= mc.aop;
      b_neg      <= bn_c;
      alu_sel    <= sel_c;
    end
  end

  // R4
  store_only_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_write |-> ($past(opcode) == OP_SW && !reg_write));

  // R3
  load_path_chk: assert property (@(posedge clk) disable iff (rst)
    mem_read |-> (mem_to_reg && reg_write && alu_src && alu_op == 2'b00));

  // R5
  branch_sub_chk: assert property (@(posedge clk) disable iff (rst)
    branch |-> (b_neg && alu_sel == 2'b10 && !reg_write));

  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_read, mem_write, branch, jump}));

  // R10
  bad_fn_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_dst && reg_write) |->
      ($past(funct) == FN_ADD || $past(funct) == FN_SUB || $past(funct) == FN_AND ||
       $past(funct) == FN_OR  || $past(funct) == FN_SLT));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(opcode) && $stable(funct) && !$past(rst)) |=> $stable(alu_op));
endmodule

// File: tb/tb_ctrl_decoder.sv
module tb_ctrl_decoder;
  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;
  logic [5:0] funct;
  logic reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump, b_neg;
  logic [1:0] alu_op, alu_sel;
  logic [12:0] got;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [5:0] op; logic [5:0] fn; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  ctrl_decoder dut (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .reg_dst(reg_dst), .alu_src(alu_src), .mem_to_reg(mem_to_reg),
    .reg_write(reg_write), .mem_read(mem_read), .mem_write(mem_write),
    .branch(branch), .jump(jump), .alu_op(alu_op), .b_neg(b_neg), .alu_sel(alu_sel)
  );

  assign got = {reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write,
                branch, jump, alu_op, b_neg, alu_sel};

  function automatic logic fn_valid(input logic [5:0] f);
    return f == 6'h20 || f == 6'h22 || f == 6'h24 || f == 6'h25 || f == 6'h2A;
  endfunction

  // Model of R2..R10: {reg_dst,alu_src,mem_to_reg,reg_write,mem_read,mem_write,branch,jump,alu_op,b_neg,alu_sel}
  function automatic logic [12:0] model(input logic [5:0] op, input logic [5:0] f);
    logic [12:0] e;
    case (op)
      6'd0: begin
        if (!fn_valid(f)) e = 13'b1000000_0_10_0_00;
        else case (f)
          6'h20: e = 13'b1001000_0_10_0_10;
          6'h22: e = 13'b1001000_0_10_1_10;
          6'h24: e = 13'b1001000_0_10_0_00;
          6'h25: e = 13'b1001000_0_10_0_01;
          default: e = 13'b1001000_0_10_1_11;
        endcase
      end
      6'd35: e = 13'b0111100_0_00_0_10;
      6'd43: e = 13'b0100010_0_00_0_10;
      6'd4:  e = 13'b0000001_0_01_1_10;
      6'd2:  e = 13'b0000000_1_00_0_10;
      default: e = 13'b0000000_0_00_0_10;
    endcase
    return e;
  endfunction

  function automatic string tag(input logic [5:0] op, input logic [5:0] f);
    case (op)
      6'd0:  return fn_valid(f) ? "R2 R9 R11" : "R10 R11";
      6'd35: return "R3 R8 R11";
      6'd43: return "R4 R8 R11";
      6'd4:  return "R5 R8 R11";
      6'd2:  return "R6 R11";
      default: return "R7 R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [5:0] f);
    item_t it;
    @(negedge clk);
    opcode = op;
    funct  = f;
    it.op = op;
    it.fn = f;
    q.push_back(it);
  endtask

  // Monitor: scores each registered result one edge after its inputs (R11)
  always @(posedge clk) begin
    #2;
    if (!rst && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(tag(it.op, it.fn), got, model(it.op, it.fn));
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    opcode = 6'd35;
    funct = 6'h20;
    repeat (3) @(posedge clk);
    #2 check("R1 reset with load presented", got, 13'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int op = 0; op < 64; op++)
      for (int f = 0; f < 64; f++)
        drive(6'(op), 6'(f));

    drive(6'd2, 6'h00);
    @(negedge clk);
    opcode = 6'd35;
    funct  = 6'h00;
    #1 check("R11 hold until edge", got, model(6'd2, 6'h00));
    begin
      item_t it;
      it.op = 6'd35;
      it.fn = 6'h00;
      q.push_back(it);
    end
    @(posedge clk);
    #3;
    while (q.size() > 0) begin
      @(posedge clk);
      #3;
    end

    @(negedge clk);
    rst = 1'b1;
    opcode = 6'd0;
    funct = 6'h20;
    @(posedge clk);
    #2 check("R1 reset mid-stream", got, 13'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule